// File: doc/BRIEF.md
# Tagged Transmit Command Consumer

This block sits on the read side of a transmit FIFO whose 36-bit entries mix packet commands and packet data. The upper four bits of each entry are a tag: zero marks a start-of-packet command, and any other value marks a data or end-of-packet entry. When the packet scheduler pulses the run-packet strobe, the block pops the head entry. If that entry is a well-formed command, the block hands the decoded transaction fields to the packet issue logic. It always finishes with exactly one completion pulse that carries an OK, bad-command or timeout code.

When the scheduler signals an underrun, the block emits a one-cycle forced-bad-CRC pulse and then enters a purge state. In that state it discards stale entries until the FIFO is empty or a start-of-packet entry reaches the head. That entry is left in place for the next run-packet strobe. A data entry is never decoded as a command, and an empty FIFO cannot hang the block, because the wait for a command is bounded by a cycle counter.

Top module: `txcmd_consumer`

## Requirements
- R1: After reset, `cmdReady` is 1 and `fifoRdEn`, `badCrc`, `pktValid` and `doneValid` are 0.
- R2: A run-packet strobe accepted while `cmdReady` is 1 with a well-formed command at the FIFO head pops exactly that one entry. Two clock edges after the strobe is sampled, `pktValid` and `doneValid` pulse together with `doneCode` 0 (OK). The fields are PID = bits 3:0, toggle = bits 5:4, endpoint type = bits 7:6, speed = bits 9:8, address = bits 22:16, endpoint number = bits 29:23.
- R3: If the head entry has a nonzero tag (bits 35:32) when a command is fetched, it is popped and the completion carries `doneCode` 1 (bad command), with `pktValid` low.
- R4: A tag-zero entry whose PID is 0 or whose reserved bits (31:30 or 15:10) are nonzero is also completed with `doneCode` 1 and no `pktValid`.
- R5: While the FIFO is empty during a fetch, nothing is popped. Data that arrives before the limit is then fetched and completed normally, one edge after it appears.
- R6: If the FIFO stays empty for WAIT_LIMIT cycles of the fetch, the completion carries `doneCode` 2 (timeout), WAIT_LIMIT+1 edges after the strobe is sampled.
- R7: An underrun sampled while idle produces a `badCrc` pulse exactly one cycle wide on the next cycle, followed by purging.
- R8: Purging pops entries with a nonzero tag one per cycle. It stops without popping when the head is a tag-zero entry or when the FIFO is empty, and it never pops an empty FIFO.
- R9: Each accepted strobe yields exactly one completion pulse. Strobes that arrive while `cmdReady` is 0 are ignored.
- R10: If an underrun and a run-packet strobe are sampled in the same idle cycle, the underrun wins and the strobe is not accepted, so no completion follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEmpty | input | 1 | FIFO has no entry at its head |
| fifoRdData | input | 36 | Head entry of the FIFO (show-ahead) |
| fifoRdEn | output | 1 | Pop the head entry at this edge |
| runPkt | input | 1 | Run-packet strobe from the scheduler |
| underrun | input | 1 | Underrun / bus-timeout indication |
| cmdReady | output | 1 | Block is idle and will accept a strobe |
| badCrc | output | 1 | Force a bad-CRC end on the current packet |
| pktValid | output | 1 | Decoded fields are valid this cycle |
| pktPid | output | 4 | Decoded PID |
| pktToggle | output | 2 | Decoded data toggle |
| pktEpType | output | 2 | Decoded endpoint type |
| pktSpeed | output | 2 | Decoded endpoint speed |
| pktAddr | output | 7 | Decoded device address |
| pktEpNum | output | 7 | Decoded endpoint number |
| doneValid | output | 1 | Completion pulse |
| doneCode | output | 2 | Completion code: 0 OK, 1 bad command, 2 timeout |

## Verification
When the head entry is already present, a completion is due two edges after the strobe is sampled. When data arrives late, it is due one edge after the data appears. A timeout is due WAIT_LIMIT+1 edges after the strobe. The bad-CRC pulse is due on the edge after the underrun. The driver stamps every expected completion with its due cycle, and the monitor compares both the code and the cycle when the pulse appears, so an early, late, missing or extra completion is reported. Purge results are checked through the FIFO occupancy the bench keeps, and by fetching the entry that should have survived.

// File: rtl/txcmd_pkg.sv
package txcmd_pkg;
  localparam int ENTRY_W = 36;
  localparam int TAG_W   = 4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_CRCBAD = 2'd2,
    ST_PURGE  = 2'd3
  } ctlState_t;

  typedef enum logic [1:0] {
    DONE_OK      = 2'd0,
    DONE_BADCMD  = 2'd1,
    DONE_TIMEOUT = 2'd2
  } doneCode_t;

  typedef struct packed {
    logic pop;
    logic loadFields;
    logic doneOk;
    logic doneBad;
    logic doneTmo;
    logic waitClr;
    logic waitInc;
  } ctlStrobe_t;

  typedef struct packed {
    logic [3:0] pid;
    logic [1:0] toggle;
    logic [1:0] epType;
    logic [1:0] speed;
    logic [6:0] addr;
    logic [6:0] epNum;
  } pktFields_t;
endpackage

// File: rtl/txcmd_datapath.sv
module txcmd_datapath
  import txcmd_pkg::*;
#(
  parameter int WAIT_LIMIT = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ENTRY_W-1:0] fifoRdData,
  input  ctlStrobe_t         strb,
  output logic               isSop,
  output logic               cmdWellFormed,
  output logic               waitExpired,
  output logic               pktValid,
  output pktFields_t         fields,
  output logic               doneValid,
  output logic [1:0]         doneCode
);
  localparam int WAIT_W = (WAIT_LIMIT > 2) ? $clog2(WAIT_LIMIT) : 1;

  logic [TAG_W-1:0] tag;
  logic [1:0]       rsvdHi;
  logic [5:0]       rsvdLo;
  pktFields_t       decoded;
  logic [WAIT_W-1:0] waitCnt;

  // Field positions of a start-of-packet command word
  assign tag            = fifoRdData[ENTRY_W-1 -: TAG_W];
  assign rsvdHi         = fifoRdData[31:30];
  assign rsvdLo         = fifoRdData[15:10];
  assign decoded.epNum  = fifoRdData[29:23];
  assign decoded.addr   = fifoRdData[22:16];
  assign decoded.speed  = fifoRdData[9:8];
  assign decoded.epType = fifoRdData[7:6];
  assign decoded.toggle = fifoRdData[5:4];
  assign decoded.pid    = fifoRdData[3:0];

  assign isSop         = (tag == '0);
  assign cmdWellFormed = isSop && (decoded.pid != 4'h0) &&
                         (rsvdHi == 2'b00) && (rsvdLo == 6'b0);
  assign waitExpired   = (waitCnt == WAIT_W'(WAIT_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktValid  <= 1'b0;
      fields    <= '0;
      doneValid <= 1'b0;
      doneCode  <= DONE_OK;
      waitCnt   <= '0;
    end else begin
      pktValid  <= strb.loadFields;
      doneValid <= strb.doneOk | strb.doneBad | strb.doneTmo;
      if (strb.doneTmo)      doneCode <= DONE_TIMEOUT;
      else if (strb.doneBad) doneCode <= DONE_BADCMD;
      else if (strb.doneOk)  doneCode <= DONE_OK;
      if (strb.loadFields)   fields   <= decoded;
      if (strb.waitClr)      waitCnt  <= '0;
      else if (strb.waitInc) waitCnt  <= waitCnt + 1'b1;
    end
  end

  AST_PKT_WITH_OK: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> (doneValid && doneCode == DONE_OK)); // R2
  AST_ONE_DONE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.doneOk, strb.doneBad, strb.doneTmo})); // R9
  AST_LOAD_ONLY_SOP: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadFields |-> isSop); // R3
endmodule

// File: rtl/txcmd_control.sv
module txcmd_control
  import txcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoEmpty,
  input  logic       runPkt,
  input  logic       underrun,
  input  logic       isSop,
  input  logic       cmdWellFormed,
  input  logic       waitExpired,
  output ctlStrobe_t strb,
  output logic       cmdReady,
  output logic       badCrc
);
  ctlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        strb.waitClr = 1'b1;
        if (underrun)    stateNext = ST_CRCBAD;
        else if (runPkt) stateNext = ST_FETCH;
      end
      ST_FETCH: begin
        if (!fifoEmpty) begin
          strb.pop = 1'b1;
          if (cmdWellFormed) begin
            strb.loadFields = 1'b1;
            strb.doneOk     = 1'b1;
          end else begin
            strb.doneBad = 1'b1;
          end
          stateNext = ST_IDLE;
        end else if (waitExpired) begin
          strb.doneTmo = 1'b1;
          stateNext    = ST_IDLE;
        end else begin
          strb.waitInc = 1'b1;
        end
      end
      ST_CRCBAD: stateNext = ST_PURGE;
      ST_PURGE: begin
        if (fifoEmpty || isSop) stateNext = ST_IDLE;
        else                    strb.pop  = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign cmdReady = (state == ST_IDLE);
  assign badCrc   = (state == ST_CRCBAD);

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> !fifoEmpty); // R8
  AST_BADCRC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    badCrc |=> !badCrc); // R7
  AST_TMO_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strb.doneTmo |-> fifoEmpty); // R6
endmodule

// File: rtl/txcmd_consumer.sv
module txcmd_consumer
  import txcmd_pkg::*;
#(
  parameter int WAIT_LIMIT = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fifoEmpty,
  input  logic [35:0] fifoRdData,
  output logic        fifoRdEn,
  input  logic        runPkt,
  input  logic        underrun,
  output logic        cmdReady,
  output logic        badCrc,
  output logic        pktValid,
  output logic [3:0]  pktPid,
  output logic [1:0]  pktToggle,
  output logic [1:0]  pktEpType,
  output logic [1:0]  pktSpeed,
  output logic [6:0]  pktAddr,
  output logic [6:0]  pktEpNum,
  output logic        doneValid,
  output logic [1:0]  doneCode
);
  ctlStrobe_t strb;
  pktFields_t fields;
  logic isSop, cmdWellFormed, waitExpired;

  txcmd_control u_ctl (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .runPkt(runPkt),
    .underrun(underrun), .isSop(isSop), .cmdWellFormed(cmdWellFormed),
    .waitExpired(waitExpired), .strb(strb), .cmdReady(cmdReady),
    .badCrc(badCrc)
  );

  txcmd_datapath #(.WAIT_LIMIT(WAIT_LIMIT)) u_dp (
    .clk(clk), .rstN(rstN), .fifoRdData(fifoRdData), .strb(strb),
    .isSop(isSop), .cmdWellFormed(cmdWellFormed), .waitExpired(waitExpired),
    .pktValid(pktValid), .fields(fields), .doneValid(doneValid),
    .doneCode(doneCode)
  );

  assign fifoRdEn  = strb.pop;
  assign pktPid    = fields.pid;
  assign pktToggle = fields.toggle;
  assign pktEpType = fields.epType;
  assign pktSpeed  = fields.speed;
  assign pktAddr   = fields.addr;
  assign pktEpNum  = fields.epNum;

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !$past(cmdReady)); // R9
  AST_CRC_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    badCrc |-> !doneValid); // R7
endmodule

// File: tb/tb_txcmd_consumer.sv
module tb_txcmd_consumer;
  localparam int WAIT_LIMIT = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runPkt = 1'b0, underrun = 1'b0;
  logic fifoEmpty, fifoRdEn, cmdReady, badCrc, pktValid, doneValid;
  logic [35:0] fifoRdData;
  logic [3:0] pktPid;
  logic [1:0] pktToggle, pktEpType, pktSpeed, doneCode;
  logic [6:0] pktAddr, pktEpNum;

  always #5 clk = ~clk;

  // Bench-side FIFO model
  logic [35:0] mem [0:63];
  int wrPtr = 0, rdPtr = 0, cyc = 0;
  assign fifoEmpty  = (rdPtr == wrPtr);
  assign fifoRdData = mem[rdPtr % 64];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fifoRdEn && rdPtr != wrPtr) rdPtr <= rdPtr + 1;
  end

  txcmd_consumer #(.WAIT_LIMIT(WAIT_LIMIT)) dut (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .fifoRdData(fifoRdData),
    .fifoRdEn(fifoRdEn), .runPkt(runPkt), .underrun(underrun),
    .cmdReady(cmdReady), .badCrc(badCrc), .pktValid(pktValid),
    .pktPid(pktPid), .pktToggle(pktToggle), .pktEpType(pktEpType),
    .pktSpeed(pktSpeed), .pktAddr(pktAddr), .pktEpNum(pktEpNum),
    .doneValid(doneValid), .doneCode(doneCode)
  );

  typedef struct {
    logic [1:0]  code;
    logic [35:0] word;
    int          due;
    string       req;
  } exp_t;
  exp_t sbQ[$];

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [35:0] mkSop(input logic [3:0] pid, input logic [1:0] tog,
      input logic [1:0] typ, input logic [1:0] spd, input logic [6:0] adr,
      input logic [6:0] ep);
    return {4'h0, 2'b00, ep, adr, 6'b0, spd, typ, tog, pid};
  endfunction

  task automatic push(input logic [35:0] w);
    mem[wrPtr % 64] = w;
    wrPtr++;
  endtask

  task automatic strobe(input int dueOfs, input logic [1:0] code,
                        input logic [35:0] w, input string req);
    exp_t e;
    @(negedge clk);
    runPkt = 1'b1;
    e.code = code; e.word = w; e.due = cyc + dueOfs; e.req = req;
    sbQ.push_back(e);
    @(negedge clk);
    runPkt = 1'b0;
  endtask

  // Monitor: compares completions against the scoreboard, including due cycle
  always @(negedge clk) begin
    exp_t e;
    if (rstN) begin
      if (doneValid) begin
        if (sbQ.size() == 0) begin
          check(1'b0, "R9", "unexpected completion", doneCode, 0);
        end else begin
          e = sbQ.pop_front();
          check(doneCode == e.code, e.req, "done code", doneCode, e.code);
          check(cyc == e.due, e.req, "done cycle", cyc, e.due);
          if (e.code == 2'd0) begin
            check(pktValid == 1'b1, e.req, "pktValid", pktValid, 1);
            check({pktEpNum, pktAddr, pktSpeed, pktEpType, pktToggle, pktPid} ==
                  {e.word[29:23], e.word[22:16], e.word[9:8], e.word[7:6],
                   e.word[5:4], e.word[3:0]}, e.req, "fields",
                  {pktEpNum, pktAddr, pktSpeed, pktEpType, pktToggle, pktPid},
                  {e.word[29:23], e.word[22:16], e.word[9:8], e.word[7:6],
                   e.word[5:4], e.word[3:0]});
          end else begin
            check(pktValid == 1'b0, e.req, "pktValid on error", pktValid, 0);
          end
        end
      end else if (pktValid) begin
        check(1'b0, "R2", "pktValid without completion", 1, 0);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    int k = 0;
    while ((sbQ.size() != 0 || !cmdReady) && k < 100) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [35:0] w;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cmdReady == 1'b1, "R1", "cmdReady", cmdReady, 1);
    check(fifoRdEn == 1'b0, "R1", "fifoRdEn", fifoRdEn, 0);
    check(badCrc == 1'b0 && pktValid == 1'b0 && doneValid == 1'b0, "R1",
          "pulses", {badCrc, pktValid, doneValid}, 0);

    // R2 well-formed commands, several field patterns, data trailing stays
    w = mkSop(4'h1, 2'b01, 2'b10, 2'b11, 7'h55, 7'h2A); push(w); push(36'h3_1234_5678);
    strobe(2, 2'd0, w, "R2"); drain();
    check(wrPtr - rdPtr == 1, "R2", "one pop", wrPtr - rdPtr, 1);
    rdPtr = wrPtr;
    w = mkSop(4'hD, 2'b10, 2'b01, 2'b00, 7'h7F, 7'h7F); push(w);
    strobe(2, 2'd0, w, "R2"); drain();
    w = mkSop(4'h9, 2'b00, 2'b11, 2'b01, 7'h01, 7'h40); push(w);
    strobe(2, 2'd0, w, "R2"); drain();

    // R3 data entry at head is not a command
    push(36'hC_3002_910C);
    strobe(2, 2'd1, 0, "R3"); drain();
    check(fifoEmpty == 1'b1, "R3", "data entry popped", fifoEmpty, 1);

    // R4 malformed tag-zero entries
    push(mkSop(4'h0, 2'b00, 2'b00, 2'b00, 7'h03, 7'h01));
    strobe(2, 2'd1, 0, "R4"); drain();
    push(mkSop(4'h1, 2'b00, 2'b00, 2'b00, 7'h03, 7'h01) | 36'h0_4000_0000);
    strobe(2, 2'd1, 0, "R4"); drain();
    push(mkSop(4'h1, 2'b00, 2'b00, 2'b00, 7'h03, 7'h01) | 36'h0_0000_0400);
    strobe(2, 2'd1, 0, "R4"); drain();

    // R5 late data; fetch waits without popping
    w = mkSop(4'h5, 2'b11, 2'b01, 2'b10, 7'h22, 7'h11);
    @(negedge clk); runPkt = 1'b1; n = cyc;
    @(negedge clk); runPkt = 1'b0;
    idle(2);
    check(fifoRdEn == 1'b0 && cmdReady == 1'b0, "R5", "waiting",
          {fifoRdEn, cmdReady}, 0);
    push(w);
    sbQ.push_back('{code: 2'd0, word: w, due: cyc + 1, req: "R5"});
    drain();

    // R6 timeout, plus R9 strobe while busy is ignored
    strobe(WAIT_LIMIT + 1, 2'd2, 0, "R6");
    check(cmdReady == 1'b0, "R9", "busy", cmdReady, 0);
    @(negedge clk); runPkt = 1'b1; @(negedge clk); runPkt = 1'b0;
    drain(); idle(4);
    check(sbQ.size() == 0, "R9", "no extra completion pending", sbQ.size(), 0);

    // R7/R8 underrun: bad CRC then purge stops at tag-zero entry
    push(36'hC_0000_0001); push(36'h5_0000_0002);
    w = mkSop(4'hA, 2'b01, 2'b11, 2'b10, 7'h33, 7'h05); push(w); push(36'h7_0000_0003);
    @(negedge clk); underrun = 1'b1;
    @(negedge clk); underrun = 1'b0;
    check(badCrc == 1'b1, "R7", "badCrc pulse", badCrc, 1);
    @(negedge clk);
    check(badCrc == 1'b0, "R7", "badCrc one cycle", badCrc, 0);
    idle(6);
    check(wrPtr - rdPtr == 2, "R8", "purge kept command", wrPtr - rdPtr, 2);
    check(cmdReady == 1'b1, "R8", "back to idle", cmdReady, 1);
    strobe(2, 2'd0, w, "R8"); drain();
    rdPtr = wrPtr;

    // R8 purge stops on empty
    push(36'h3_0000_0004); push(36'h9_0000_0005);
    @(negedge clk); underrun = 1'b1;
    @(negedge clk); underrun = 1'b0;
    idle(8);
    check(fifoEmpty == 1'b1, "R8", "purged to empty", fifoEmpty, 1);
    check(cmdReady == 1'b1, "R8", "idle after empty", cmdReady, 1);

    // R10 underrun beats strobe in same cycle
    w = mkSop(4'h3, 2'b00, 2'b10, 2'b01, 7'h0F, 7'h0E); push(w);
    @(negedge clk); underrun = 1'b1; runPkt = 1'b1;
    @(negedge clk); underrun = 1'b0; runPkt = 1'b0;
    idle(8);
    check(wrPtr - rdPtr == 1, "R10", "command untouched", wrPtr - rdPtr, 1);
    strobe(2, 2'd0, w, "R10"); drain();

    idle(4);
    check(sbQ.size() == 0, "R9", "all completions seen", sbQ.size(), 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule